// File: doc/BRIEF.md
# Memory Hole Relocation Unit

This unit keeps the setup of a DRAM hole that sits below the 4 GiB line and translates system addresses around it. The hole starts at a programmable base and runs to 0xFFFF_FFFF. The DRAM that this window would otherwise hide is reached again from 0x1_0000_0000 upward. The unit holds a single configuration register with a valid bit, an 8-bit base field and an 8-bit offset field. Each field supplies bits 31:24 of its full 32-bit value.

From the register the unit shows three values on its status pins: the hole base, the hole size and the relocation offset. A hole-valid flag also appears there. The flag is set only when three inputs agree: a feature-present input, a hoisting-enable input and the register's valid bit. Addresses move on a valid/ready stream. An address inside the relocated window has the offset subtracted. Every other address comes out unchanged.

Back-pressure follows these rules. A beat is accepted in a cycle where `in_valid` and `in_ready` are both high. Its result shows on the output one cycle later. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output beat holds still and no new beat is accepted.

Top module: `hole_reloc`

## Requirements
- R1: After reset the configuration register is zero, `hole_valid` is 0, `out_valid` is 0, `in_ready` is 1, `hole_base` is 0 and `hole_size` is 0x1_0000_0000.
- R2: `hole_base` equals register bits 31:24 placed at bits 31:24, with the lower 24 bits zero. A write takes effect in the cycle after `cfg_we`.
- R3: `hole_size` (33 bits) equals 2^32 minus `hole_base`.
- R4: `hole_offset` takes register bits 15:8 when `layout_sel` is 0 and bits 14:7 when `layout_sel` is 1. In both cases the field is shifted left by 24 with zero fill.
- R5: `hole_valid` is 1 only when `feat_present` is 1, `hoist_en` is 1 and register bit 0 is 1.
- R6: When the hole is valid, an address in [0x1_0000_0000, 0x1_0000_0000 + size - 1] comes out as address minus offset, and `out_reloc` is 1.
- R7: Any address outside that window, and every address while the hole is invalid, comes out unchanged with `out_reloc` 0.
- R8: A beat accepted in cycle n shows `out_valid` high with its result in cycle n+1.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_addr` and `out_reloc` hold their values.
- R10: A beat accepted in the same cycle as a register write is translated with the register contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_present | input | 1 | Hole feature exists on this part |
| hoist_en | input | 1 | Global memory hoisting enable |
| layout_sel | input | 1 | Offset field position: 0 = bits 15:8, 1 = bits 14:7 |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Configuration register write data |
| in_valid | input | 1 | Input address beat valid |
| in_ready | output | 1 | Unit can accept an input beat |
| in_addr | input | 40 | System address to translate |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_addr | output | 40 | Translated address |
| out_reloc | output | 1 | Output address was relocated |
| hole_valid | output | 1 | Hole information is valid |
| hole_base | output | 32 | Decoded hole base |
| hole_size | output | 33 | Decoded hole size |
| hole_offset | output | 32 | Decoded relocation offset |

## Verification
A register write and an accepted translation beat can happen in the same cycle. The bench raises `cfg_we` and `in_valid` on the same clock edge. The address it sends lies outside the old window but inside the new one, so it must pass through unchanged. Sending the same address again afterwards must relocate it under the new setting. Stalls get separate tests: a beat is held under `out_ready` low while a second beat waits, and afterwards both must leave in order with unchanged values.

// File: rtl/hole_pkg.sv
package hole_pkg;
  localparam int REG_W    = 32;
  localparam int FLD_W    = 8;
  localparam int FLD_SH   = 24;
  localparam int BASE_LSB = 24;
  localparam int OFS0_LSB = 8;
  localparam int OFS1_LSB = 7;
  localparam int VLD_BIT  = 0;
  localparam int HALF_W   = 32;

  typedef struct packed {
    logic              valid;
    logic [HALF_W-1:0] base;
    logic [HALF_W:0]   size;
    logic [HALF_W-1:0] offset;
  } hole_info_t;
endpackage

// File: rtl/hole_cfg_reg.sv
module hole_cfg_reg
  import hole_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             feat_present,
  input  logic             hoist_en,
  input  logic             layout_sel,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output hole_info_t       info
);
  logic [REG_W-1:0] cfg_q;
  logic [FLD_W-1:0] base_fld, ofs_fld;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  assign base_fld = cfg_q[BASE_LSB +: FLD_W];
  assign ofs_fld  = layout_sel ? cfg_q[OFS1_LSB +: FLD_W] : cfg_q[OFS0_LSB +: FLD_W];

  always_comb begin
    info.valid  = feat_present & hoist_en & cfg_q[VLD_BIT];
    info.base   = {base_fld, {FLD_SH{1'b0}}};
    info.offset = {ofs_fld, {FLD_SH{1'b0}}};
    info.size   = {1'b1, {HALF_W{1'b0}}} - {1'b0, info.base};
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> info.base == {$past(cfg_wdata[BASE_LSB +: FLD_W]), {FLD_SH{1'b0}}}); // R2
endmodule

// File: rtl/hole_xlate.sv
module hole_xlate
  import hole_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  hole_info_t        info,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              reloc_o
);
  localparam int CMP_W = ADDR_W + 1;
  localparam logic [CMP_W-1:0] WIN_LO = CMP_W'(1) << HALF_W;

  logic [CMP_W-1:0] win_hi, addr_x;
  logic             in_win;

  assign addr_x = {1'b0, addr_i};
  assign win_hi = WIN_LO + CMP_W'(info.size);
  assign in_win = (addr_x >= WIN_LO) && (addr_x < win_hi);

  always_comb begin
    reloc_o = info.valid && in_win;
    addr_o  = reloc_o ? addr_i - ADDR_W'(info.offset) : addr_i;
  end
endmodule

// File: rtl/hole_out_stage.sv
module hole_out_stage #(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              reloc_d,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_reloc
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_reloc <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr  <= addr_d;
        out_reloc <= reloc_d;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_reloc)); // R9
  AST_ACCEPT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R8
endmodule

// File: rtl/hole_reloc.sv
module hole_reloc
  import hole_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feat_present,
  input  logic              hoist_en,
  input  logic              layout_sel,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_reloc,
  output logic              hole_valid,
  output logic [31:0]       hole_base,
  output logic [32:0]       hole_size,
  output logic [31:0]       hole_offset
);
  hole_info_t        info;
  logic [ADDR_W-1:0] xl_addr;
  logic              xl_reloc;

  hole_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .feat_present(feat_present), .hoist_en(hoist_en),
    .layout_sel(layout_sel), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .info(info)
  );

  hole_xlate #(.ADDR_W(ADDR_W)) u_xl (
    .info(info), .addr_i(in_addr), .addr_o(xl_addr), .reloc_o(xl_reloc)
  );

  hole_out_stage #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .addr_d(xl_addr), .reloc_d(xl_reloc), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_reloc(out_reloc)
  );

  assign hole_valid  = info.valid;
  assign hole_base   = info.base;
  assign hole_size   = info.size;
  assign hole_offset = info.offset;

  AST_NO_RELOC_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !hole_valid |=> !out_reloc); // R7
  AST_ABSENT_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !feat_present || !hoist_en |-> !hole_valid); // R5
endmodule

// File: tb/hole_reloc_tb_top.sv
module hole_reloc_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        feat_present = 0, hoist_en = 0, layout_sel = 0;
  logic        cfg_we = 0;
  logic [31:0] cfg_wdata = 0;
  logic        in_valid = 0, out_ready = 1;
  logic [39:0] in_addr = 0;
  logic        in_ready, out_valid, out_reloc, hole_valid;
  logic [39:0] out_addr;
  logic [31:0] hole_base, hole_offset;
  logic [32:0] hole_size;
  int checks = 0, fails = 0;
  logic [31:0] shadow = 0;

  always #2 clk = ~clk;

  hole_reloc dut_i (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] e_base(logic [31:0] r);
    return {r[31:24], 24'h0};
  endfunction
  function automatic logic [31:0] e_ofs(logic [31:0] r, logic l);
    return l ? {r[14:7], 24'h0} : {r[15:8], 24'h0};
  endfunction
  function automatic logic [40:0] e_xl(logic [31:0] r, logic [39:0] a);
    logic [40:0] sz;
    logic v;
    v = feat_present && hoist_en && r[0];
    sz = 41'h1_0000_0000 - {9'h0, e_base(r)};
    if (v && {1'b0, a} >= 41'h1_0000_0000 && {1'b0, a} < 41'h1_0000_0000 + sz)
      return {1'b1, a - {8'h0, e_ofs(r, layout_sel)}};
    return {1'b0, a};
  endfunction

  task automatic wr(logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_wdata = d;
    @(negedge clk); cfg_we = 0; shadow = d;
  endtask

  task automatic send_chk(string req, logic [39:0] a);
    logic [40:0] e;
    e = e_xl(shadow, a);
    @(negedge clk); in_valid = 1; in_addr = a;
    @(negedge clk); in_valid = 0;
    chk(req, out_valid, 1);
    chk(req, {out_reloc, out_addr}, e);
  endtask

  task automatic t_reset;
    chk("R1", hole_valid, 0); chk("R1", out_valid, 0); chk("R1", in_ready, 1);
    chk("R1", hole_base, 0); chk("R1", hole_size, 33'h1_0000_0000);
  endtask

  task automatic t_decode;
    feat_present = 1; hoist_en = 1; layout_sel = 0;
    wr(32'hC000_4001);
    chk("R2", hole_base, 32'hC000_0000);
    chk("R3", hole_size, 33'h0_4000_0000);
    chk("R4", hole_offset, e_ofs(shadow, 0));
    chk("R4", hole_offset, 32'h4000_0000);
    layout_sel = 1; #1;
    chk("R4", hole_offset, 32'h8000_0000);
    layout_sel = 0; #1;
    wr(32'h0000_0000);
    chk("R3", hole_size, 33'h1_0000_0000);
  endtask

  task automatic t_valid;
    wr(32'hC000_4001);
    feat_present = 1; hoist_en = 1; #1; chk("R5", hole_valid, 1);
    feat_present = 0; #1; chk("R5", hole_valid, 0);
    feat_present = 1; hoist_en = 0; #1; chk("R5", hole_valid, 0);
    hoist_en = 1; wr(32'hC000_4000); chk("R5", hole_valid, 0);
    wr(32'hC000_4001); chk("R5", hole_valid, 1);
  endtask

  task automatic t_xlate;
    send_chk("R6", 40'h01_0000_0000);
    chk("R6", out_addr, 40'h00_C000_0000);
    send_chk("R6", 40'h01_3FFF_FFFF);
    chk("R6", out_addr, 40'h00_FFFF_FFFF);
    send_chk("R7", 40'h01_4000_0000); chk("R7", out_reloc, 0);
    send_chk("R7", 40'h00_FFFF_FFFF); chk("R7", out_reloc, 0);
    send_chk("R7", 40'h00_0000_0050);
    hoist_en = 0;
    send_chk("R7", 40'h01_0000_0000); chk("R7", out_reloc, 0);
    hoist_en = 1;
    layout_sel = 1;
    send_chk("R6", 40'h01_2000_0000);
    layout_sel = 0;
  endtask

  task automatic t_stall;
    logic [40:0] ea, eb;
    ea = e_xl(shadow, 40'h01_0000_1000);
    eb = e_xl(shadow, 40'h02_0000_0000);
    @(negedge clk); out_ready = 0; in_valid = 1; in_addr = 40'h01_0000_1000;
    @(negedge clk); in_addr = 40'h02_0000_0000;
    chk("R8", out_valid, 1);
    for (int i = 0; i < 3; i++) begin
      chk("R9", in_ready, 0);
      chk("R9", {out_reloc, out_addr}, ea);
      @(negedge clk);
    end
    out_ready = 1; #1;
    chk("R9", in_ready, 1);
    @(negedge clk); in_valid = 0;
    chk("R9", {out_reloc, out_addr}, eb);
    @(negedge clk);
    chk("R8", out_valid, 0);
  endtask

  task automatic t_collide;
    logic [40:0] e_old;
    e_old = e_xl(shadow, 40'h01_4000_0000);
    @(negedge clk); cfg_we = 1; cfg_wdata = 32'h8000_8001;
    in_valid = 1; in_addr = 40'h01_4000_0000;
    @(negedge clk); cfg_we = 0; in_valid = 0; shadow = 32'h8000_8001;
    chk("R10", {out_reloc, out_addr}, e_old);
    chk("R10", out_reloc, 0);
    send_chk("R10", 40'h01_4000_0000);
    chk("R10", out_addr, 40'h00_C000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    t_reset();
    t_decode();
    t_valid();
    t_xlate();
    t_stall();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule